// File: doc/BRIEF.md
# Multi-Pattern Byte-Aligned String Matcher

This block scans a continuous byte stream for any of a bank of stored 32-bit patterns. Every clock it accepts two 32-bit words, one per lane. Each 4-byte window of the stream is compared against every pattern slot, whatever byte it starts on, including windows that begin in one word and end in the next. With the default configuration of two lanes, four byte offsets and 64 slots, the block makes 512 equality comparisons per clock and never stalls.

Patterns are loaded one slot per cycle through a write port that carries a slot address, the 32-bit pattern and an enable bit. Writes can happen while the stream is running, so the pattern set can change without breaking the stream connection. For every accepted beat, each lane reports a registered result two cycles later. The result holds a hit bit per slot, an any-hit flag and the index of the lowest slot that hit.

Top module: `smatch_core`

## Requirements
- R1: A beat with `in_valid` high is accepted on every clock with no stall. Its result appears with `out_valid` high exactly two clock edges after the edge that accepts it. `out_valid` is low two edges after any edge where `in_valid` is low.
- R2: Lane l carries `in_data[32l+31:32l]`, and the byte in bits [31:24] is the earliest byte of that word. The window at byte offset k (0..3) is the last k bytes of the preceding stream word followed by the first 4-k bytes of the current word. Offset 0 is the word itself.
- R3: The word that precedes lane 1 is the lane 0 word of the same beat. The word that precedes lane 0 is the lane 1 word of the most recent earlier beat that had `in_valid` high. Cycles with `in_valid` low leave this history unchanged.
- R4: After reset and until the first valid beat has been accepted, lane 0 windows at offsets 1 to 3 never report a match.
- R5: Hit bit p of a lane (`out_hits[64l+p]`) is set when slot p is enabled and its pattern equals the lane's window at one or more offsets.
- R6: `out_any[l]` is high exactly when at least one hit bit of lane l is set.
- R7: `out_idx[6l+5:6l]` is the lowest p whose hit bit is set in lane l, and it is 0 when the lane has no hit.
- R8: A slot whose stored enable bit is 0 never sets its hit bit, even when its pattern matches a window.
- R9: When `wr_en` is high, slot `wr_addr` takes `wr_data` and `wr_pat_en`. A beat accepted in the same cycle as the write is compared against the old slot contents. Beats accepted in later cycles use the new contents.
- R10: Reset clears all outputs and leaves every slot disabled.
- R11: While `out_valid` is low, `out_hits`, `out_any` and `out_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat qualifier |
| in_data | input | 64 | Two stream words; lane 0 in the low half |
| wr_en | input | 1 | Pattern slot write strobe |
| wr_addr | input | 6 | Slot index to write |
| wr_data | input | 32 | Pattern value to store |
| wr_pat_en | input | 1 | Enable bit stored with the pattern |
| out_valid | output | 1 | Result qualifier, two cycles after the beat |
| out_hits | output | 128 | Per-slot hit bits; lane 0 in the low 64 bits |
| out_any | output | 2 | Any-hit flag per lane |
| out_idx | output | 12 | Lowest hit slot per lane; lane 0 in the low 6 bits |

## Verification
A pattern write and a stream beat can fall in the same cycle. The bench drives a write that turns a slot into the exact value of a beat presented on the same edge. It expects that beat to report the slot's old contents, and it expects the identical beat one cycle later to report the new ones. Idle cycles that carry matching data are inserted between beats, both to confirm that the lane 0 history survives the gaps and to confirm that the outputs stay zero. The bench's reference model computes every window of every beat arithmetically and checks each result.

// File: rtl/smatch_pkg.sv
package smatch_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      PRIO_LINEAR  = 1'b0,
      PRIO_GROUPED = 1'b1
   } prio_kind_e;
endpackage

// File: rtl/smatch_bank.sv
module smatch_bank #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NUM_PAT = 64,
   parameter int unsigned IDX_W   = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_addr,
   input  logic [WORD_W-1:0]           wr_data,
   input  logic                        wr_pat_en,
   output logic [NUM_PAT*WORD_W-1:0]   pat_flat,
   output logic [NUM_PAT-1:0]          pat_en
);
   for (genvar p = 0; p < NUM_PAT; p++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_addr == IDX_W'(p));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pat_flat[p*WORD_W +: WORD_W] <= '0;
            pat_en[p]                    <= 1'b0;
         end else if (sel) begin
            pat_flat[p*WORD_W +: WORD_W] <= wr_data;
            pat_en[p]                    <= wr_pat_en;
         end
      end
   end
endmodule

// File: rtl/smatch_window.sv
module smatch_window
   import smatch_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   localparam int unsigned BYTES = WORD_W / BYTE_W
) (
   input  logic [WORD_W-1:0]       prev_word,
   input  logic [WORD_W-1:0]       cur_word,
   input  logic                    hist_ok,
   output logic [BYTES*WORD_W-1:0] win_flat,
   output logic [BYTES-1:0]        win_ok
);
   logic [2*WORD_W-1:0] joined;
   assign joined = {prev_word, cur_word};

   for (genvar k = 0; k < BYTES; k++) begin : g_off
      assign win_flat[k*WORD_W +: WORD_W] = joined[WORD_W-1+BYTE_W*k -: WORD_W];
      if (k == 0) begin : g_own
         assign win_ok[k] = 1'b1;
      end else begin : g_span
         assign win_ok[k] = hist_ok;
      end
   end
endmodule

// File: rtl/smatch_lane_cmp.sv
module smatch_lane_cmp
   import smatch_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NUM_PAT = 64,
   localparam int unsigned BYTES  = WORD_W / BYTE_W
) (
   input  logic [BYTES*WORD_W-1:0]   win_flat,
   input  logic [BYTES-1:0]          win_ok,
   input  logic [NUM_PAT*WORD_W-1:0] pat_flat,
   input  logic [NUM_PAT-1:0]        pat_en,
   output logic [NUM_PAT-1:0]        hit
);
   for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      logic [BYTES-1:0] at_off;
      for (genvar k = 0; k < BYTES; k++) begin : g_off
         assign at_off[k] = win_ok[k] &&
            (win_flat[k*WORD_W +: WORD_W] == pat_flat[p*WORD_W +: WORD_W]);
      end
      assign hit[p] = pat_en[p] && (|at_off);
   end
endmodule

// File: rtl/smatch_prio.sv
module smatch_prio
   import smatch_pkg::*;
#(
   parameter int unsigned NUM_PAT = 64,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned GROUP   = 8,
   parameter prio_kind_e  KIND    = PRIO_GROUPED
) (
   input  logic [NUM_PAT-1:0] hit,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   assign any = |hit;

   if (KIND == PRIO_LINEAR) begin : g_linear
      always_comb begin
         idx = '0;
         for (int i = NUM_PAT - 1; i >= 0; i--) begin
            if (hit[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_grouped
      localparam int unsigned NGRP = NUM_PAT / GROUP;
      if ((NUM_PAT % GROUP) != 0 || GROUP < 2) begin : g_bad_group
         $error("smatch_prio: GROUP must be at least 2 and divide NUM_PAT");
      end
      logic [NGRP-1:0] grp_any;
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_any[g] = |hit[g*GROUP +: GROUP];
      end
      always_comb begin : c_pick
         int              gsel;
         int              lo;
         logic [GROUP-1:0] sub;
         gsel = 0;
         for (int g = NGRP - 1; g >= 0; g--) begin
            if (grp_any[g]) gsel = g;
         end
         sub = hit[gsel*GROUP +: GROUP];
         lo  = 0;
         for (int i = GROUP - 1; i >= 0; i--) begin
            if (sub[i]) lo = i;
         end
         idx = IDX_W'(gsel * GROUP + lo);
      end
   end
endmodule

// File: rtl/smatch_core.sv
module smatch_core
   import smatch_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned LANES      = 2,
   parameter int unsigned NUM_PAT    = 64,
   parameter int unsigned PRIO_GROUP = 8,
   parameter prio_kind_e  PRIO_KIND  = PRIO_GROUPED,
   localparam int unsigned BYTES     = WORD_W / BYTE_W,
   localparam int unsigned IDX_W     = $clog2(NUM_PAT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [LANES*WORD_W-1:0]    in_data,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_addr,
   input  logic [WORD_W-1:0]          wr_data,
   input  logic                       wr_pat_en,
   output logic                       out_valid,
   output logic [LANES*NUM_PAT-1:0]   out_hits,
   output logic [LANES-1:0]           out_any,
   output logic [LANES*IDX_W-1:0]     out_idx
);
   if ((WORD_W % BYTE_W) != 0 || BYTES < 2) begin : g_bad_word
      $error("smatch_core: WORD_W must be a multiple of 8 and at least 16");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("smatch_core: LANES must be at least 1");
   end
   if (NUM_PAT < 2) begin : g_bad_pat
      $error("smatch_core: NUM_PAT must be at least 2");
   end

   logic [NUM_PAT*WORD_W-1:0] bank_pat;
   logic [NUM_PAT-1:0]        bank_en;

   smatch_bank #(.WORD_W(WORD_W), .NUM_PAT(NUM_PAT), .IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_pat_en (wr_pat_en),
      .pat_flat  (bank_pat),
      .pat_en    (bank_en)
   );

   // stream history: last lane word of the most recent valid beat
   logic [WORD_W-1:0] hist_q;
   logic              hist_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q    <= '0;
         hist_ok_q <= 1'b0;
      end else if (in_valid) begin
         hist_q    <= in_data[(LANES-1)*WORD_W +: WORD_W];
         hist_ok_q <= 1'b1;
      end
   end

   logic [LANES*NUM_PAT-1:0] cmp_hit;
   logic                     s1_valid;
   logic [LANES*NUM_PAT-1:0] s1_hit;
   logic [LANES-1:0]         any_c;
   logic [LANES*IDX_W-1:0]   idx_c;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WORD_W-1:0]       prev_w;
      logic                    prev_ok;
      logic [BYTES*WORD_W-1:0] win_flat;
      logic [BYTES-1:0]        win_ok;

      if (l == 0) begin : g_head
         assign prev_w  = hist_q;
         assign prev_ok = hist_ok_q;
      end else begin : g_follow
         assign prev_w  = in_data[(l-1)*WORD_W +: WORD_W];
         assign prev_ok = 1'b1;
      end

      smatch_window #(.WORD_W(WORD_W)) u_win (
         .prev_word (prev_w),
         .cur_word  (in_data[l*WORD_W +: WORD_W]),
         .hist_ok   (prev_ok),
         .win_flat  (win_flat),
         .win_ok    (win_ok)
      );

      smatch_lane_cmp #(.WORD_W(WORD_W), .NUM_PAT(NUM_PAT)) u_cmp (
         .win_flat (win_flat),
         .win_ok   (win_ok),
         .pat_flat (bank_pat),
         .pat_en   (bank_en),
         .hit      (cmp_hit[l*NUM_PAT +: NUM_PAT])
      );

      smatch_prio #(
         .NUM_PAT (NUM_PAT),
         .IDX_W   (IDX_W),
         .GROUP   (PRIO_GROUP),
         .KIND    (PRIO_KIND)
      ) u_prio (
         .hit (s1_hit[l*NUM_PAT +: NUM_PAT]),
         .any (any_c[l]),
         .idx (idx_c[l*IDX_W +: IDX_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_hit    <= '0;
         out_valid <= 1'b0;
         out_hits  <= '0;
         out_any   <= '0;
         out_idx   <= '0;
      end else begin
         s1_valid  <= in_valid;
         s1_hit    <= in_valid ? cmp_hit : '0;
         out_valid <= s1_valid;
         out_hits  <= s1_hit;
         out_any   <= any_c;
         out_idx   <= idx_c;
      end
   end
endmodule

// File: rtl/smatch_chk.sv
module smatch_chk #(
   parameter int unsigned LANES   = 2,
   parameter int unsigned NUM_PAT = 64,
   parameter int unsigned IDX_W   = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     out_valid,
   input logic [LANES*NUM_PAT-1:0] out_hits,
   input logic [LANES-1:0]         out_any,
   input logic [LANES*IDX_W-1:0]   out_idx,
   input logic [NUM_PAT-1:0]       pat_en
);
   AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);                                         // R1
   AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid);                                       // R1

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [NUM_PAT-1:0] hv;
      logic [IDX_W-1:0]   ix;
      assign hv = out_hits[l*NUM_PAT +: NUM_PAT];
      assign ix = out_idx[l*IDX_W +: IDX_W];

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> (hv == '0) && !out_any[l] && (ix == '0));         // R11
      AST_ANY_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
         out_any[l] == (|hv));                                             // R6
      AST_IDX_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         out_any[l] |-> hv[ix]);                                           // R7
      AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
         out_any[l] |-> ((hv & ~({NUM_PAT{1'b1}} << ix)) == '0));          // R7
      AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !out_any[l] |-> (ix == '0));                                      // R7
      AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (hv & ~$past(pat_en, 2)) == '0);                                  // R8
   end
endmodule

bind smatch_core smatch_chk #(
   .LANES   (LANES),
   .NUM_PAT (NUM_PAT),
   .IDX_W   (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_hits  (out_hits),
   .out_any   (out_any),
   .out_idx   (out_idx),
   .pat_en    (bank_en)
);

// File: tb/test_smatch_core.sv
module test_smatch_core;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [63:0]  in_data = '0;
   logic         wr_en = 1'b0;
   logic [5:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         wr_pat_en = 1'b0;
   logic         out_valid;
   logic [127:0] out_hits;
   logic [1:0]   out_any;
   logic [11:0]  out_idx;

   always #2.5 clk = ~clk;

   smatch_core i_smatch_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_pat_en(wr_pat_en),
      .out_valid(out_valid), .out_hits(out_hits), .out_any(out_any), .out_idx(out_idx)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_pat [64];
   logic        m_en  [64];
   logic [31:0] m_hist;
   logic        m_hok;

   // expectation slots: slot A = beat driven last step, slot B = the one before
   logic         a_v, b_v;
   logic [127:0] a_h, b_h;
   logic [1:0]   a_a, b_a;
   logic [11:0]  a_i, b_i;
   string        a_tag, b_tag;

   logic [31:0] lcg = 32'h1234_5678;

   function automatic logic [31:0] consec(input logic [7:0] b);
      return {b, b + 8'd1, b + 8'd2, b + 8'd3};
   endfunction

   function automatic logic [63:0] lane_hits(input logic [31:0] prev,
                                             input logic [31:0] cur,
                                             input logic ok);
      logic [63:0] joined;
      logic [63:0] sh;
      logic [63:0] r;
      r = '0;
      joined = {prev, cur};
      for (int p = 0; p < 64; p++) begin
         if (m_en[p]) begin
            for (int k = 0; k < 4; k++) begin
               sh = joined >> (8 * k);
               if ((k == 0 || ok) && sh[31:0] == m_pat[p]) r[p] = 1'b1;
            end
         end
      end
      return r;
   endfunction

   function automatic logic [5:0] lowest(input logic [63:0] h);
      logic [5:0] ix;
      ix = '0;
      for (int p = 63; p >= 0; p--) if (h[p]) ix = 6'(p);
      return ix;
   endfunction

   task automatic check_now(input logic v, input logic [127:0] h,
                            input logic [1:0] a, input logic [11:0] i,
                            input string tag);
      checks++;
      if (out_valid !== v || out_hits !== h || out_any !== a || out_idx !== i) begin
         failures++;
         $display("FAIL %s: got v=%0b hits=%h any=%b idx=%h, expected v=%0b hits=%h any=%b idx=%h",
                  tag, out_valid, out_hits, out_any, out_idx, v, h, a, i);
      end
   endtask

   task automatic clear_model();
      for (int p = 0; p < 64; p++) begin
         m_pat[p] = '0;
         m_en[p]  = 1'b0;
      end
      m_hist = '0;
      m_hok  = 1'b0;
      a_v = 1'b0; a_h = '0; a_a = '0; a_i = '0; a_tag = "R10 R11";
      b_v = 1'b0; b_h = '0; b_a = '0; b_i = '0; b_tag = "R10 R11";
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; wr_en = 1'b0;
      clear_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_now(1'b0, '0, '0, '0, "R10 reset state");
   endtask

   // one clock: check the beat from two steps back, then drive a new cycle
   task automatic step(input logic v, input logic [31:0] d0, input logic [31:0] d1,
                       input logic we, input logic [5:0] wa, input logic [31:0] wd,
                       input logic wen, input string tag);
      logic [63:0] h0, h1;
      check_now(b_v, b_h, b_a, b_i, b_tag);
      in_valid = v; in_data = {d1, d0};
      wr_en = we; wr_addr = wa; wr_data = wd; wr_pat_en = wen;
      h0 = '0; h1 = '0;
      if (v) begin
         h0 = lane_hits(m_hist, d0, m_hok);
         h1 = lane_hits(d0, d1, 1'b1);
      end
      b_v = a_v; b_h = a_h; b_a = a_a; b_i = a_i; b_tag = a_tag;
      a_v = v; a_h = {h1, h0}; a_a = {|h1, |h0};
      a_i = {lowest(h1), lowest(h0)}; a_tag = tag;
      if (we) begin
         m_pat[wa] = wd;
         m_en[wa]  = wen;
      end
      if (v) begin
         m_hist = d1;
         m_hok  = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic beat(input logic [31:0] d0, input logic [31:0] d1, input string tag);
      step(1'b1, d0, d1, 1'b0, '0, '0, 1'b0, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, consec(8'd8), consec(8'd12), 1'b0, '0, '0, 1'b0, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();

      // load slots p = bytes p..p+3; slot 5 stored disabled (R8); idle data matches (R11)
      for (int p = 0; p < 64; p++)
         step(1'b0, consec(8'd8), consec(8'd12), 1'b1, 6'(p), consec(8'(p)),
              (p != 5), "R11 idle during load");
      step(1'b0, '0, '0, 1'b1, 6'd40, 32'h0000_00AA, 1'b1, "R11 idle");

      // first beat after reset: offset-3 window {00,00,00,AA} must be masked
      beat(32'hAABB_CCDD, consec(8'd1), "R4 first beat masked");
      beat(32'h1111_1111, 32'h0000_0000, "R3 set history");
      idle("R3 R11 idle gap");
      idle("R3 R11 idle gap");
      idle("R3 R11 idle gap");
      beat(32'hAA00_0000, consec(8'd20), "R3 history across gap");

      // consecutive byte stream: every offset, multi-hit lowest index
      for (int s = 0; s < 40; s++)
         beat(consec(8'(8 * s)), consec(8'(8 * s + 4)), "R1 R2 R5 R6 R7 sweep");

      // pseudo-random stream with gaps
      for (int n = 0; n < 300; n++) begin
         logic [7:0] r;
         lcg = lcg * 32'd1103515245 + 32'd12345;
         r = 8'(lcg[23:16] % 8'd72);
         step(lcg[9:8] != 2'b00, consec(r),
              lcg[10] ? consec(r + 8'd4) : {lcg[31:24], lcg[7:0], r, lcg[15:8]},
              1'b0, '0, '0, 1'b0, "R1 R3 R5 R7 random stream");
      end

      // write and beat in the same cycle: old contents apply, then new
      step(1'b1, 32'hDEAD_BEEF, consec(8'd30), 1'b1, 6'd10, 32'hDEAD_BEEF, 1'b1,
           "R9 same-cycle write uses old slot");
      beat(32'hDEAD_BEEF, consec(8'd30), "R9 next beat uses new slot");
      step(1'b1, consec(8'd11), consec(8'd15), 1'b1, 6'd11, consec(8'd11), 1'b0,
           "R9 same-cycle disable not yet seen");
      beat(consec(8'd11), consec(8'd15), "R8 disabled slot silent");
      beat(consec(8'd3), consec(8'd7), "R8 slot 5 disabled in run");
      step(1'b1, consec(8'd60), consec(8'd64), 1'b1, 6'd5, consec(8'd5), 1'b1,
           "R5 R7 high slots");
      beat(consec(8'd1), consec(8'd5), "R8 R9 slot 5 re-enabled");
      idle("R1 R11 drain");
      idle("R1 R11 drain");
      idle("R11 drain");

      // second reset: every slot disabled again
      do_reset();
      beat('0, '0, "R10 slots disabled after reset");
      beat(consec(8'd0), consec(8'd4), "R10 slots disabled after reset");
      idle("R10 drain");
      idle("R10 drain");
      idle("R10 drain");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule